// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block keeps calendar time in packed BCD: seconds, minutes, hours in 24-hour form, day of month, month, two-digit year, and a weekday counter. A one-cycle tick-enable input, pulsed once per second by the surrounding logic, advances the count while the run control bit is set. Software reaches the block through a byte-wide register bus. A write takes effect at the clock edge where the write strobe is high. A read returns its data on the registered read-data output one cycle after the read strobe.

A snapshot command copies the live counters into a shadow set. While the snapshot-view bit stays set, reads of the time bytes return the frozen copy, so a multi-byte read is coherent even though the clock keeps running. A six-byte alarm is compared against the time each tick produces. Periodic events and alarm matches collect in a write-one-to-clear status byte. A level interrupt is raised from the pending flags that are enabled, and a two-bit field selects which periodic interval drives the timer interrupt.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0. The run bit is 0, status reads 0x80 (only the power-up flag, bit 7) and irq_o is low.
- R2: A tick with control bit 0 (run) set advances seconds by one in BCD, with carries 59→00 into minutes, 59→00 into hours and 23→00 into day. A tick with run clear changes nothing.
- R3: Day rolls over to 0x01 after the last day of the month: 30 for months 0x04, 0x06, 0x09 and 0x11, 31 for the other months, and for 0x02 either 29 when the BCD year is a multiple of 4 or 28 otherwise. Month 0x12 rolls to 0x01 and carries into year, and year 0x99 rolls to 0x00.
- R4: Weekday (address 0x06) counts 0 to 6 and advances when hours roll from 23 to 00, wrapping from 6 to 0.
- R5: Writing address 0x00 to 0x06 (sec, min, hour, day, month, year, weekday) loads that counter. A write wins over a tick in the same cycle.
- R6: Writing control (0x0D) with bit 6 set copies all seven live counters into the shadow set. While the stored bit 6 is 1, reads of 0x00 to 0x06 return the shadow copy; while it is 0 they return the live counters.
- R7: Status (0x0E) bits 2, 3, 4 and 5 set when a tick advances seconds, wraps seconds, wraps minutes and wraps hours respectively. Status bit 1 reads the run bit.
- R8: Status bit 6 (alarm) sets on a tick whose new seconds, minutes, hours, day, month and year all equal the alarm bytes at 0x07 to 0x0C (same field order as the time bytes).
- R9: Writing status with a 1 in bits 2 to 7 clears those flags, and a 0 leaves them unchanged. The power-up flag (bit 7) is set only by reset.
- R10: irq_o is high while (status bit 6 and enable bit 3) or (the selected periodic flag and enable bit 2). Enable register 0x0F bits [1:0] select the flag: 0 = second (bit 2), 1 = minute (bit 3), 2 = hour (bit 4), 3 = day (bit 5).
- R11: The alarm bytes 0x07 to 0x0C and the two bytes at 0x10 and 0x11 read back what was written, and 0x0F reads back its low four bits.
- R12: rdata_o changes only in the cycle after rd_i is high. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per second |
| addr_i | input | 5 | Register byte address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Level interrupt |

## Verification
The calendar is started from chosen instants: the last second of an ordinary February, of a leap February in years 24 and 00, of a 30-day month and of year 99. These separate the month-length rule, the leap test on BCD digits and each carry stage. Seconds values in the middle of a minute and at 59 separate a per-second timer interrupt from a per-minute one. An alarm two ticks ahead shows that the match uses the time after the increment and not the time before it. A tick in the same cycle as a time write, and a tick taken while the snapshot view is on, show which source wins in each case.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] wday;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam int unsigned TIME_BYTES  = 7;
  localparam int unsigned ALARM_BYTES = 6;

  localparam logic [4:0] A_ALM0  = 5'h07;
  localparam logic [4:0] A_CTRL  = 5'h0D;
  localparam logic [4:0] A_STAT  = 5'h0E;
  localparam logic [4:0] A_IEN   = 5'h0F;
  localparam logic [4:0] A_SPARE0 = 5'h10;
  localparam logic [4:0] A_SPARE1 = 5'h11;

  // one step of a two-digit BCD counter
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of four: 10*t + u == 2*t + u (mod 4)
  function automatic logic bcd_leap(input logic [7:0] y);
    logic [5:0] s;
    s = {1'b0, y[7:4], 1'b0} + {2'b00, y[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic            ld_en_i,
  input  logic [2:0]      ld_idx_i,
  input  logic [BW-1:0]   ld_data_i,
  output rtc_time_t       now_o,
  output rtc_time_t       nxt_o,
  output logic [3:0]      ev_o
);

  rtc_time_t now_q;
  rtc_time_t nxt;

  logic c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    c_min = (now_q.sec == 8'h59);
    c_hr  = c_min & (now_q.min == 8'h59);
    c_day = c_hr  & (now_q.hr  == 8'h23);
    c_mon = c_day & (now_q.day == month_end(now_q.mon, now_q.yr));
    c_yr  = c_mon & (now_q.mon == 8'h12);

    nxt     = now_q;
    nxt.sec = c_min ? 8'h00 : bcd_step(now_q.sec);
    if (c_min) nxt.min = c_hr ? 8'h00 : bcd_step(now_q.min);
    if (c_hr)  nxt.hr  = c_day ? 8'h00 : bcd_step(now_q.hr);
    if (c_day) begin
      nxt.day  = c_mon ? 8'h01 : bcd_step(now_q.day);
      nxt.wday = (now_q.wday == 8'h06) ? 8'h00 : now_q.wday + 8'h01;
    end
    if (c_mon) nxt.mon = c_yr ? 8'h01 : bcd_step(now_q.mon);
    if (c_yr)  nxt.yr  = (now_q.yr == 8'h99) ? 8'h00 : bcd_step(now_q.yr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '{wday: 8'h00, yr: 8'h00, mon: 8'h01, day: 8'h01,
                 hr: 8'h00, min: 8'h00, sec: 8'h00};
    end else if (ld_en_i) begin
      case (ld_idx_i)
        3'd0:    now_q.sec  <= ld_data_i;
        3'd1:    now_q.min  <= ld_data_i;
        3'd2:    now_q.hr   <= ld_data_i;
        3'd3:    now_q.day  <= ld_data_i;
        3'd4:    now_q.mon  <= ld_data_i;
        3'd5:    now_q.yr   <= ld_data_i;
        default: now_q.wday <= ld_data_i;
      endcase
    end else if (adv_i) begin
      now_q <= nxt;
    end
  end

  assign now_o = now_q;
  assign nxt_o = nxt;
  // {day, hour, minute, second} events of this tick
  assign ev_o  = {adv_i & c_day, adv_i & c_hr, adv_i & c_min, adv_i};

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_pkg::*;
#(
  parameter int unsigned NB = ALARM_BYTES,
  parameter int unsigned BW = 8,
  localparam int unsigned IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [BW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [BW-1:0] rd_data_o,
  input  rtc_time_t     cand_i,
  input  logic          adv_i,
  output logic          hit_o
);

  logic [BW-1:0] alm_q [NB];
  logic [NB-1:0] eq;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     alm_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g))         alm_q[g] <= wr_data_i;
    end
    assign eq[g] = (alm_q[g] == cand_i[g*BW +: BW]);
  end

  assign rd_data_o = (rd_idx_i < IW'(NB)) ? alm_q[rd_idx_i] : '0;
  assign hit_o     = adv_i & (&eq);

endmodule

// File: rtl/rtc_event_status.sv
module rtc_event_status #(
  parameter int unsigned NEV = 4,
  localparam int unsigned NF = NEV + 2,
  localparam int unsigned SW = $clog2(NEV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NEV-1:0] ev_i,
  input  logic          alarm_hit_i,
  input  logic          clr_en_i,
  input  logic [NF-1:0] clr_mask_i,
  input  logic [SW-1:0] sel_i,
  input  logic          tmr_en_i,
  input  logic          alm_en_i,
  output logic [NF-1:0] flags_o,
  output logic          irq_o
);

  // flags: [NF-1] power-up, [NF-2] alarm, [NEV-1:0] periodic events
  logic [NF-1:0] fl_q;
  logic [NF-1:0] clr;
  logic [NF-1:0] set;

  assign clr = clr_en_i ? clr_mask_i : '0;
  assign set = {1'b0, alarm_hit_i, ev_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= {1'b1, {(NF-1){1'b0}}};
    else        fl_q <= (fl_q & ~clr) | set;
  end

  assign flags_o = fl_q;
  assign irq_o   = (fl_q[NF-2] & alm_en_i) | (fl_q[sel_i] & tmr_en_i);

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);

  localparam int unsigned NEV = 4;
  localparam int unsigned NF  = NEV + 2;
  localparam int unsigned AIW = $clog2(ALARM_BYTES);

  logic run_q, snap_q;
  logic [3:0] ien_q;
  logic [DW-1:0] spare_q [2];
  rtc_time_t shadow_q, now_time, nxt_time;

  logic adv, time_wr, alm_wr, ctrl_wr, stat_wr, alarm_hit;
  logic [NEV-1:0] ev;
  logic [NF-1:0]  flags;
  logic [AW-1:0]  alm_off;
  logic [DW-1:0]  alm_rd, rmux;
  rtc_time_t      view;

  assign adv     = tick_i & run_q;
  assign time_wr = wr_i && (addr_i < AW'(TIME_BYTES));
  assign alm_off = addr_i - AW'(A_ALM0);
  assign alm_wr  = wr_i && (addr_i >= AW'(A_ALM0)) && (alm_off < AW'(ALARM_BYTES));
  assign ctrl_wr = wr_i && (addr_i == AW'(A_CTRL));
  assign stat_wr = wr_i && (addr_i == AW'(A_STAT));

  rtc_calendar #(.BW(DW)) u_cal (
    .clk(clk), .rst_n(rst_n), .adv_i(adv),
    .ld_en_i(time_wr), .ld_idx_i(addr_i[2:0]), .ld_data_i(wdata_i),
    .now_o(now_time), .nxt_o(nxt_time), .ev_o(ev)
  );

  rtc_alarm_match #(.NB(ALARM_BYTES), .BW(DW)) u_alm (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(alm_wr), .wr_idx_i(alm_off[AIW-1:0]), .wr_data_i(wdata_i),
    .rd_idx_i(alm_off[AIW-1:0]), .rd_data_o(alm_rd),
    .cand_i(nxt_time), .adv_i(adv), .hit_o(alarm_hit)
  );

  rtc_event_status #(.NEV(NEV)) u_stat (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .alarm_hit_i(alarm_hit),
    .clr_en_i(stat_wr), .clr_mask_i(wdata_i[7:2]),
    .sel_i(ien_q[1:0]), .tmr_en_i(ien_q[2]), .alm_en_i(ien_q[3]),
    .flags_o(flags), .irq_o(irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      snap_q   <= 1'b0;
      shadow_q <= '0;
      ien_q    <= '0;
      spare_q  <= '{default: '0};
    end else if (wr_i) begin
      if (ctrl_wr) begin
        run_q  <= wdata_i[0];
        snap_q <= wdata_i[6];
        if (wdata_i[6]) shadow_q <= now_time;
      end
      if (addr_i == AW'(A_IEN))    ien_q      <= wdata_i[3:0];
      if (addr_i == AW'(A_SPARE0)) spare_q[0] <= wdata_i;
      if (addr_i == AW'(A_SPARE1)) spare_q[1] <= wdata_i;
    end
  end

  assign view = snap_q ? shadow_q : now_time;

  always_comb begin
    rmux = '0;
    if (addr_i < AW'(TIME_BYTES))       rmux = view[addr_i[2:0]*8 +: 8];
    else if (alm_wr || (addr_i >= AW'(A_ALM0) && alm_off < AW'(ALARM_BYTES)))
                                        rmux = alm_rd;
    else if (addr_i == AW'(A_CTRL))     rmux = {1'b0, snap_q, 5'b0, run_q};
    else if (addr_i == AW'(A_STAT))     rmux = {flags, run_q, 1'b0};
    else if (addr_i == AW'(A_IEN))      rmux = {4'b0, ien_q};
    else if (addr_i == AW'(A_SPARE0))   rmux = spare_q[0];
    else if (addr_i == AW'(A_SPARE1))   rmux = spare_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= rmux;
  end

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       adv,
  input logic       time_wr,
  input rtc_time_t  now,
  input logic       sec_ev,
  input logic       stat_sec,
  input logic       alarm_hit,
  input logic       stat_alarm,
  input logic       stat_pu,
  input logic       stat_wr,
  input logic [7:0] wdata,
  input logic       rd,
  input logic [7:0] rdata
);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !time_wr) |=> $stable(now));

  // R7
  sec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_ev |=> stat_sec);

  // R8
  alarm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> stat_alarm);

  // R9
  pu_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_pu) |-> $past(stat_wr && wdata[7]));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .time_wr(time_wr), .now(now_time),
  .sec_ev(ev[0]), .stat_sec(flags[0]), .alarm_hit(alarm_hit),
  .stat_alarm(flags[4]), .stat_pu(flags[5]), .stat_wr(stat_wr),
  .wdata(wdata_i), .rd(rd_i), .rdata(rdata_o)
);

// File: tb/sim_bcd_rtc_core.sv
`timescale 1ns/1ps
module sim_bcd_rtc_core;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [4:0] addr = '0;
  logic wr = 1'b0;
  logic [7:0] wdata = '0;
  logic rd = 1'b0;
  logic [7:0] rdata;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bcd_rtc_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d, mo, y, w);
    wr_reg(5'h0D, 8'h00);
    wr_reg(5'h00, s); wr_reg(5'h01, m); wr_reg(5'h02, h);
    wr_reg(5'h03, d); wr_reg(5'h04, mo); wr_reg(5'h05, y); wr_reg(5'h06, w);
    wr_reg(5'h0D, 8'h01);
  endtask

  task automatic expect_time(input string req, input logic [7:0] s, m, h, d, mo, y, w);
    logic [7:0] v;
    rd_reg(5'h00, v); chk(req, v, s);
    rd_reg(5'h01, v); chk(req, v, m);
    rd_reg(5'h02, v); chk(req, v, h);
    rd_reg(5'h03, v); chk(req, v, d);
    rd_reg(5'h04, v); chk(req, v, mo);
    rd_reg(5'h05, v); chk(req, v, y);
    rd_reg(5'h06, v); chk(req, v, w);
  endtask

  // {write, address, data-or-expected}
  localparam int NV = 12;
  localparam logic [13:0] VT [NV] = '{
    {1'b1, 5'h10, 8'hA5}, {1'b0, 5'h10, 8'hA5},
    {1'b1, 5'h11, 8'h3C}, {1'b0, 5'h11, 8'h3C},
    {1'b1, 5'h07, 8'h45}, {1'b0, 5'h07, 8'h45},
    {1'b1, 5'h0C, 8'h99}, {1'b0, 5'h0C, 8'h99},
    {1'b1, 5'h0F, 8'hF3}, {1'b0, 5'h0F, 8'h03},
    {1'b0, 5'h15, 8'h00}, {1'b0, 5'h1F, 8'h00}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_time("R1", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
    rd_reg(5'h0E, v); chk("R1", v, 8'h80);
    chk("R1", {7'b0, irq}, 8'h00);

    // R11 R12 register table
    for (int i = 0; i < NV; i++) begin
      if (VT[i][13]) wr_reg(VT[i][12:8], VT[i][7:0]);
      else begin
        rd_reg(VT[i][12:8], v);
        chk("R11/R12 table", v, VT[i][7:0]);
      end
    end
    wr_reg(5'h0F, 8'h00);

    // R2 stopped: tick has no effect
    pulse_tick();
    rd_reg(5'h00, v); chk("R2 stopped", v, 8'h00);

    // R7 run mirror, second event
    wr_reg(5'h0D, 8'h01);
    rd_reg(5'h0E, v); chk("R7 run bit", v, 8'h82);
    pulse_tick();
    rd_reg(5'h00, v); chk("R2 advance", v, 8'h01);
    rd_reg(5'h0E, v); chk("R7 sec event", v, 8'h86);

    // R9 writing 0 keeps, writing 1 clears
    wr_reg(5'h0E, 8'h00);
    rd_reg(5'h0E, v); chk("R9 zero keeps", v, 8'h86);
    wr_reg(5'h0E, 8'h80);
    rd_reg(5'h0E, v); chk("R9 clear pu", v, 8'h06);
    wr_reg(5'h0E, 8'hFC);
    rd_reg(5'h0E, v); chk("R9 clear all", v, 8'h02);

    // R3 R4 non-leap February, weekday 6 -> 0
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h06);
    wr_reg(5'h0E, 8'hFC);
    pulse_tick();
    expect_time("R3/R4 feb23", 8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23, 8'h00);
    rd_reg(5'h0E, v); chk("R7 all events", v & 8'h3C, 8'h3C);

    // R3 leap years 24 and 00
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h02);
    pulse_tick();
    expect_time("R3 leap24", 8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00, 8'h05);
    pulse_tick();
    rd_reg(5'h03, v); chk("R3 leap00", v, 8'h29);

    // R3 thirty-day month
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h31, 8'h01);
    pulse_tick();
    expect_time("R3 apr", 8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h31, 8'h02);

    // R3 end of year 99
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h04);
    pulse_tick();
    expect_time("R3 year wrap", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h05);

    // R8 R10 alarm two ticks ahead
    wr_reg(5'h07, 8'h02); wr_reg(5'h08, 8'h00); wr_reg(5'h09, 8'h00);
    wr_reg(5'h0A, 8'h01); wr_reg(5'h0B, 8'h01); wr_reg(5'h0C, 8'h00);
    wr_reg(5'h0F, 8'h08);
    wr_reg(5'h0E, 8'hFC);
    pulse_tick();
    rd_reg(5'h0E, v); chk("R8 no early alarm", v & 8'h40, 8'h00);
    chk("R10 irq low", {7'b0, irq}, 8'h00);
    pulse_tick();
    rd_reg(5'h0E, v); chk("R8 alarm set", v & 8'h40, 8'h40);
    chk("R10 alarm irq", {7'b0, irq}, 8'h01);
    wr_reg(5'h0E, 8'h40);
    chk("R10 irq after clear", {7'b0, irq}, 8'h00);

    // R10 per-second timer
    wr_reg(5'h0F, 8'h04);
    wr_reg(5'h0E, 8'hFC);
    chk("R10 timer idle", {7'b0, irq}, 8'h00);
    pulse_tick();
    chk("R10 sec timer", {7'b0, irq}, 8'h01);

    // R10 per-minute timer
    wr_reg(5'h0F, 8'h05);
    set_time(8'h30, 8'h10, 8'h05, 8'h12, 8'h06, 8'h25, 8'h01);
    wr_reg(5'h0E, 8'hFC);
    pulse_tick();
    chk("R10 min timer quiet", {7'b0, irq}, 8'h00);
    set_time(8'h59, 8'h10, 8'h05, 8'h12, 8'h06, 8'h25, 8'h01);
    pulse_tick();
    chk("R10 min timer fires", {7'b0, irq}, 8'h01);
    wr_reg(5'h0F, 8'h01);
    chk("R10 timer disabled", {7'b0, irq}, 8'h00);
    wr_reg(5'h0F, 8'h00);

    // R5 write wins over simultaneous tick
    @(negedge clk); addr = 5'h00; wdata = 8'h10; wr = 1'b1; tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    rd_reg(5'h00, v); chk("R5 write wins", v, 8'h10);
    rd_reg(5'h01, v); chk("R5 min untouched", v, 8'h11);

    // R6 snapshot view
    set_time(8'h56, 8'h34, 8'h12, 8'h15, 8'h07, 8'h26, 8'h03);
    wr_reg(5'h0D, 8'h41);
    pulse_tick();
    rd_reg(5'h00, v); chk("R6 shadow", v, 8'h56);
    rd_reg(5'h01, v); chk("R6 shadow min", v, 8'h34);
    wr_reg(5'h0D, 8'h01);
    rd_reg(5'h00, v); chk("R6 live", v, 8'h57);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule